// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single PWM command into the two gate enables of a synchronous buck power stage: one for the high-side switch and one for the low-side switch. It never turns one switch on while the other may still be conducting. Instead of a fixed dead time, it waits for digitised feedback from the power stage. One flag says the low-side gate has discharged. A second says the switch node has fallen. A third says the high-side gate has discharged. Only after the relevant flag is seen does it apply a short programmable delay before turning on the opposite switch.

If the switch node never falls after the high side turns off, the low side still turns on. A backup timer starts counting once the high-side gate is discharged and turns the low side on when it expires. This keeps the bootstrap capacitor charging every cycle.

The block also gates its outputs with four inputs:
- a supply-good flag, already hysteretic;
- an active-low output disable;
- a tri-state shutdown flag from the PWM input decoder;
- an active-low skip input that keeps the low side off for diode emulation at light load.

Top module: `gate_seq`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, both gh_en and gl_en are low.
- R2: If supply_ok is low or out_dis_n is low at a clock edge, both gh_en and gl_en are low after that edge, whatever pwm_cmd is. Once both are high again, the sequence restarts from the all-off state.
- R3: If tri_off is high at a clock edge, both gh_en and gl_en are low after that edge. They stay low while it is held.
- R4: On a rising pwm_cmd (1 = high side), gl_en drops at the first edge. gh_en stays low for as long as ls_gate_low is 0. Once ls_gate_low is sampled 1, gh_en rises on the (DEAD_ON_CYC+1)-th edge that follows, counting the sampling edge.
- R5: On a falling pwm_cmd with skip_n high, gh_en drops at the first edge. gl_en stays low while sw_node_low is 0 and the backup timer has not expired. Once sw_node_low is sampled 1, gl_en rises on the (DEAD_OFF_CYC+1)-th edge, counting the sampling edge.
- R6: While waiting for the switch node with sw_node_low at 0, gl_en rises on the TIMEOUT_CYC-th edge that samples hs_gate_low at 1.
- R7: With skip_n low, gl_en never rises and drops at the next edge if it was high. gh_en still follows pwm_cmd using the R4 sequence.
- R8: In steady state with the block enabled, gh_en equals pwm_cmd. gl_en equals the inverse of pwm_cmd when skip_n is high.
- R9: gh_en and gl_en are never high in the same cycle. Neither one rises in the cycle right after the other was high.
- R10: A pwm_cmd change during a dead-time wait abandons the pending turn-on at once and starts the sequence toward the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_cmd | input | 1 | Decoded PWM command, 1 = high side on |
| tri_off | input | 1 | Tri-state shutdown from the PWM decoder, 1 = both gates off |
| supply_ok | input | 1 | Hysteretic undervoltage status, 1 = supply good |
| out_dis_n | input | 1 | Output disable, 0 = both gates off |
| skip_n | input | 1 | Skip control, 0 = low side held off (diode emulation) |
| ls_gate_low | input | 1 | Low-side gate discharged |
| sw_node_low | input | 1 | Switch node has fallen below its threshold |
| hs_gate_low | input | 1 | High-side gate discharged |
| gh_en | output | 1 | High-side gate enable |
| gl_en | output | 1 | Low-side gate enable |

## Verification
The gate enables are decoded directly from the state register, so any turn-off caused by a command, disable, tri-state or skip input is due after one clock edge. A turn-on is due DEAD_ON_CYC+1 or DEAD_OFF_CYC+1 edges after the matching feedback flag is first sampled. On the backup path, it is due TIMEOUT_CYC edges after the first edge that samples hs_gate_low. The bench drives inputs on the falling clock edge and advances an exact number of rising edges before sampling at the next falling edge. At the boundaries it checks both sides: the output is still low one edge before the expected turn-on and high at the expected edge.

// File: rtl/gate_seq_pkg.sv
`timescale 1ns/1ps
package gate_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_LS_OFF,
    ST_DEAD_ON,
    ST_HS_ON,
    ST_WAIT_SW_LOW,
    ST_DEAD_OFF,
    ST_LS_ON
  } gseq_state_e;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_HS,
    TGT_LS
  } gseq_tgt_e;

endpackage

// File: rtl/gate_seq_target.sv
`timescale 1ns/1ps
module gate_seq_target
  import gate_seq_pkg::*;
(
  input  logic      pwm_cmd,
  input  logic      tri_off,
  input  logic      supply_ok,
  input  logic      out_dis_n,
  input  logic      skip_n,
  output gseq_tgt_e tgt
);

  logic active;

  assign active = supply_ok & out_dis_n & ~tri_off;

  // Disabled, tri-stated, or low phase in diode emulation: nothing on.
  always_comb begin
    if (!active)      tgt = TGT_NONE;
    else if (pwm_cmd) tgt = TGT_HS;
    else if (skip_n)  tgt = TGT_LS;
    else              tgt = TGT_NONE;
  end

endmodule

// File: rtl/gate_seq_delay.sv
`timescale 1ns/1ps
module gate_seq_delay #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          cnt_en;

  assign done = run && (cnt == LAST);

  always_comb begin
    cnt_en  = 1'b0;
    cnt_nxt = cnt;
    if (!run) begin
      cnt_en  = (cnt != '0);
      cnt_nxt = '0;
    end else if (!done) begin
      cnt_en  = 1'b1;
      cnt_nxt = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

endmodule

// File: rtl/gate_seq_fsm.sv
`timescale 1ns/1ps
module gate_seq_fsm
  import gate_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  gseq_tgt_e   tgt,
  input  logic        ls_gate_low,
  input  logic        sw_node_low,
  input  logic        hs_gate_low,
  input  logic        don_done,
  input  logic        doff_done,
  input  logic        tmo_done,
  output logic        don_run,
  output logic        doff_run,
  output logic        tmo_run,
  output logic        gh_en,
  output logic        gl_en
);

  gseq_state_e st;
  gseq_state_e st_nxt;
  logic        st_en;

  function automatic gseq_state_e head_for(gseq_tgt_e t);
    case (t)
      TGT_HS:  return ST_WAIT_LS_OFF;
      TGT_LS:  return ST_WAIT_SW_LOW;
      default: return ST_OFF;
    endcase
  endfunction

  always_comb begin
    st_nxt = st;
    case (st)
      ST_OFF: st_nxt = head_for(tgt);
      ST_WAIT_LS_OFF: begin
        if (tgt != TGT_HS)    st_nxt = head_for(tgt);
        else if (ls_gate_low) st_nxt = ST_DEAD_ON;
      end
      ST_DEAD_ON: begin
        if (tgt != TGT_HS)    st_nxt = head_for(tgt);
        else if (don_done)    st_nxt = ST_HS_ON;
      end
      ST_HS_ON: begin
        if (tgt != TGT_HS)    st_nxt = head_for(tgt);
      end
      ST_WAIT_SW_LOW: begin
        if (tgt != TGT_LS)    st_nxt = head_for(tgt);
        else if (sw_node_low) st_nxt = ST_DEAD_OFF;
        else if (tmo_done)    st_nxt = ST_LS_ON;
      end
      ST_DEAD_OFF: begin
        if (tgt != TGT_LS)    st_nxt = head_for(tgt);
        else if (doff_done)   st_nxt = ST_LS_ON;
      end
      ST_LS_ON: begin
        if (tgt != TGT_LS)    st_nxt = head_for(tgt);
      end
      default: st_nxt = ST_OFF;
    endcase
  end

  assign st_en = (st_nxt != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st <= ST_OFF;
    else if (st_en) st <= st_nxt;
  end

  assign don_run  = (st == ST_DEAD_ON);
  assign doff_run = (st == ST_DEAD_OFF);
  assign tmo_run  = (st == ST_WAIT_SW_LOW) && hs_gate_low;
  assign gh_en    = (st == ST_HS_ON);
  assign gl_en    = (st == ST_LS_ON);

  // R4
  ls_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT_LS_OFF && tgt == TGT_HS && !ls_gate_low) |=> (st == ST_WAIT_LS_OFF));

  // R10
  abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEAD_ON && tgt != TGT_HS) |=> !gh_en);

endmodule

// File: rtl/gate_seq.sv
`timescale 1ns/1ps
module gate_seq
  import gate_seq_pkg::*;
#(
  parameter int unsigned DEAD_ON_CYC  = 2,
  parameter int unsigned DEAD_OFF_CYC = 3,
  parameter int unsigned TIMEOUT_CYC  = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_cmd,
  input  logic tri_off,
  input  logic supply_ok,
  input  logic out_dis_n,
  input  logic skip_n,
  input  logic ls_gate_low,
  input  logic sw_node_low,
  input  logic hs_gate_low,
  output logic gh_en,
  output logic gl_en
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s_n;
  gseq_tgt_e              tgt;
  logic                   don_run, doff_run, tmo_run;
  logic                   don_done, doff_done, tmo_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_STAGES-1];

  gate_seq_target u_tgt (
    .pwm_cmd  (pwm_cmd),
    .tri_off  (tri_off),
    .supply_ok(supply_ok),
    .out_dis_n(out_dis_n),
    .skip_n   (skip_n),
    .tgt      (tgt)
  );

  gate_seq_delay #(.LIMIT(DEAD_ON_CYC)) u_dead_on (
    .clk(clk), .rst_n(rst_s_n), .run(don_run), .done(don_done)
  );

  gate_seq_delay #(.LIMIT(DEAD_OFF_CYC)) u_dead_off (
    .clk(clk), .rst_n(rst_s_n), .run(doff_run), .done(doff_done)
  );

  gate_seq_delay #(.LIMIT(TIMEOUT_CYC)) u_timeout (
    .clk(clk), .rst_n(rst_s_n), .run(tmo_run), .done(tmo_done)
  );

  gate_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .tgt        (tgt),
    .ls_gate_low(ls_gate_low),
    .sw_node_low(sw_node_low),
    .hs_gate_low(hs_gate_low),
    .don_done   (don_done),
    .doff_done  (doff_done),
    .tmo_done   (tmo_done),
    .don_run    (don_run),
    .doff_run   (doff_run),
    .tmo_run    (tmo_run),
    .gh_en      (gh_en),
    .gl_en      (gl_en)
  );

  // R9
  hs_after_ls_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(gh_en) |-> !$past(gl_en));

  // R9
  ls_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(gl_en) |-> !$past(gh_en));

  // R2
  disable_off_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(supply_ok && out_dis_n && !tri_off) |=> (!gh_en && !gl_en));

  // R7
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(gl_en) |-> $past(skip_n));

  // R4
  hs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(gh_en) |-> $past(pwm_cmd));

endmodule

// File: tb/gate_seq_tb.sv
`timescale 1ns/1ps
module gate_seq_tb;

  localparam int unsigned DON  = 2;
  localparam int unsigned DOFF = 3;
  localparam int unsigned TMO  = 25;

  logic clk = 1'b0;
  logic rst_n;
  logic pwm_cmd, tri_off, supply_ok, out_dis_n, skip_n;
  logic ls_gate_low, sw_node_low, hs_gate_low;
  logic gh_en, gl_en;

  int checks = 0;
  int errors = 0;
  int overlaps = 0;

  always #5 clk = ~clk;

  gate_seq #(.DEAD_ON_CYC(DON), .DEAD_OFF_CYC(DOFF), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .tri_off(tri_off),
    .supply_ok(supply_ok), .out_dis_n(out_dis_n), .skip_n(skip_n),
    .ls_gate_low(ls_gate_low), .sw_node_low(sw_node_low), .hs_gate_low(hs_gate_low),
    .gh_en(gh_en), .gl_en(gl_en)
  );

  always @(negedge clk) if (gh_en && gl_en) overlaps++;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_hs();
    ls_gate_low = 1'b1; pwm_cmd = 1'b1; step(10);
  endtask

  task automatic go_ls();
    sw_node_low = 1'b1; hs_gate_low = 1'b1; pwm_cmd = 1'b0; step(10);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    pwm_cmd = 1'b0; tri_off = 1'b0; supply_ok = 1'b1; out_dis_n = 1'b1; skip_n = 1'b1;
    ls_gate_low = 1'b1; sw_node_low = 1'b1; hs_gate_low = 1'b1;
    step(3);
    chk("R1", "gh in reset", gh_en, 1'b0);
    chk("R1", "gl in reset", gl_en, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk("R1", "gh after release", gh_en, 1'b0);
    chk("R1", "gl after release", gl_en, 1'b0);
    step(12);
    chk("R8", "gl steady low pwm", gl_en, 1'b1);
    chk("R8", "gh steady low pwm", gh_en, 1'b0);
  endtask

  task automatic t_rise();
    ls_gate_low = 1'b0; pwm_cmd = 1'b1;
    step(1);
    chk("R4", "gl drops first", gl_en, 1'b0);
    chk("R4", "gh not yet", gh_en, 1'b0);
    step(4);
    chk("R4", "gh waits ls flag", gh_en, 1'b0);
    ls_gate_low = 1'b1;
    step(DON);
    chk("R4", "gh inside dead-on", gh_en, 1'b0);
    step(1);
    chk("R4", "gh after dead-on", gh_en, 1'b1);
    chk("R8", "gl low with pwm high", gl_en, 1'b0);
  endtask

  task automatic t_fall();
    sw_node_low = 1'b0; hs_gate_low = 1'b0; pwm_cmd = 1'b0;
    step(1);
    chk("R5", "gh drops first", gh_en, 1'b0);
    chk("R5", "gl not yet", gl_en, 1'b0);
    step(4);
    chk("R5", "gl waits sw flag", gl_en, 1'b0);
    sw_node_low = 1'b1;
    step(DOFF);
    chk("R5", "gl inside dead-off", gl_en, 1'b0);
    step(1);
    chk("R5", "gl after dead-off", gl_en, 1'b1);
    hs_gate_low = 1'b1;
  endtask

  task automatic t_timeout();
    go_hs();
    sw_node_low = 1'b0; hs_gate_low = 1'b0; pwm_cmd = 1'b0;
    step(6);
    chk("R6", "gl idle before hs flag", gl_en, 1'b0);
    hs_gate_low = 1'b1;
    step(TMO - 1);
    chk("R6", "gl one edge before timeout", gl_en, 1'b0);
    step(1);
    chk("R6", "gl at timeout", gl_en, 1'b1);
    sw_node_low = 1'b1;
  endtask

  task automatic t_skip();
    go_ls();
    skip_n = 1'b0;
    step(1);
    chk("R7", "gl drops on skip", gl_en, 1'b0);
    pwm_cmd = 1'b1;
    step(DON + 2);
    chk("R7", "gh follows pwm in skip", gh_en, 1'b1);
    pwm_cmd = 1'b0;
    step(1);
    chk("R7", "gh drops in skip", gh_en, 1'b0);
    step(10);
    chk("R7", "gl held low in skip", gl_en, 1'b0);
    skip_n = 1'b1;
    step(10);
    chk("R8", "gl back after skip", gl_en, 1'b1);
  endtask

  task automatic t_disable();
    out_dis_n = 1'b0;
    step(1);
    chk("R2", "gl off on disable", gl_en, 1'b0);
    pwm_cmd = 1'b1;
    step(5);
    chk("R2", "gh held off disabled", gh_en, 1'b0);
    chk("R2", "gl held off disabled", gl_en, 1'b0);
    out_dis_n = 1'b1;
    step(DON + 1);
    chk("R2", "gh restart not early", gh_en, 1'b0);
    step(1);
    chk("R2", "gh restart sequence", gh_en, 1'b1);
    supply_ok = 1'b0;
    step(1);
    chk("R2", "gh off on supply loss", gh_en, 1'b0);
    chk("R2", "gl off on supply loss", gl_en, 1'b0);
    supply_ok = 1'b1; pwm_cmd = 1'b0;
    step(10);
    chk("R2", "gl back after supply", gl_en, 1'b1);
  endtask

  task automatic t_tri();
    tri_off = 1'b1;
    step(1);
    chk("R3", "gl off on tri", gl_en, 1'b0);
    pwm_cmd = 1'b1;
    step(5);
    chk("R3", "gh held off tri", gh_en, 1'b0);
    pwm_cmd = 1'b0;
    tri_off = 1'b0;
    step(10);
    chk("R3", "gl after tri exit", gl_en, 1'b1);
  endtask

  task automatic t_abort();
    ls_gate_low = 1'b1; pwm_cmd = 1'b1;
    step(2);
    sw_node_low = 1'b0; hs_gate_low = 1'b0; pwm_cmd = 1'b0;
    step(DON + 3);
    chk("R10", "gh never rises after abort", gh_en, 1'b0);
    chk("R10", "gl waits sw after abort", gl_en, 1'b0);
    sw_node_low = 1'b1;
    step(DOFF + 1);
    chk("R10", "gl on new target", gl_en, 1'b1);
    hs_gate_low = 1'b1;
  endtask

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_timeout();
    t_skip();
    t_disable();
    t_tri();
    t_abort();
    checks++;
    if (overlaps != 0) begin
      errors++;
      $display("FAIL R9 overlap cycles: actual=%0d expected=0", overlaps);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule